// File: doc/BRIEF.md
# Register-Format Execution Unit

This block executes one register-to-register instruction per clock. The 32-bit instruction word is split into six fixed fields. A zero major opcode marks the register format, and the function code then chooses the operation. The unit reads two operands from its own 32 x 32-bit register file. It computes a sum, a difference, a bitwise AND, or a logical shift, and stores the result in the destination register on the rising clock edge.

The result, the destination index and an illegal-instruction flag are combinational outputs for the word currently presented. A debug port reads any register combinationally. The same port can also write a register. After reset every register is zero, and the register-format operations alone cannot make a nonzero value, so the debug write is the only way to preload operands.

Top module: `rfmt_exec_unit`

## Requirements
- R1: The instruction fields, from most to least significant bit, are: major opcode [31:26], first source index [25:21], second source index [20:16], destination index [15:11], shift amount [10:6] and function code [5:0]. `dest_o` always equals bits [15:11] of `instr_i`.
- R2: Function code 32 writes first source plus second source, wrapping modulo 2^32 (for example, the word 0x02324020 adds registers 17 and 18 into register 8).
- R3: Function code 34 writes first source minus second source, wrapping modulo 2^32.
- R4: Function code 36 writes the bitwise AND of the two sources.
- R5: Function code 0 writes the second source shifted left by the shift-amount field, with zeros shifted in.
- R6: Function code 2 writes the second source shifted right by the shift-amount field, with zeros shifted in.
- R7: A valid word is illegal if its opcode is nonzero, if its function code is not one of {0, 2, 32, 34, 36}, or if it is a shift (code 0 or 2) with a nonzero first source field. An illegal word sets `illegal_o`, drives `result_o` to 0 and writes no register.
- R8: A register is written only on a rising edge where `instr_vld_i` is high. While `instr_vld_i` is low, `illegal_o` is 0 and no register changes unless the debug port writes it.
- R9: A synchronous active-low reset clears all 32 registers to zero.
- R10: A read of a register during the cycle it is written returns the old value. The new value can be read from the next cycle on.
- R11: `dbg_data_o` shows the register chosen by `dbg_addr_i` combinationally. With `dbg_we_i` high, `dbg_wdata_i` is stored there on the clock edge. If an instruction writes the same register in the same cycle, the instruction result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| instr_vld_i | input | 1 | Instruction valid strobe |
| result_o | output | 32 | Result of the current instruction (0 when illegal) |
| dest_o | output | 5 | Destination register index field |
| illegal_o | output | 1 | Valid word is not an executable register-format instruction |
| dbg_addr_i | input | 5 | Debug register index |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_data_o | output | 32 | Debug read data |

## Verification
A corrupted register shows up on `dbg_data_o` as soon as that index is selected. It shows up on `result_o` in the same cycle that any later instruction uses the register as a source. A write to the wrong register, or a missed write, can be seen one cycle after the instruction, because the bench selects the destination on the debug port both before and after every edge. A decode fault shows up at once on `illegal_o` or `result_o`, and the random mix of function codes, opcodes and source fields reaches every legal and illegal class.

// File: rtl/rfx_pkg.sv
// Package rfx_pkg
// Purpose: shared field layout, function codes and operation type for the
//          register-format execution unit.
// Assumes: a 32-bit instruction word with 5-bit register indices.
package rfx_pkg;

    localparam int INSTR_W = 32;
    localparam int IDX_W   = 5;
    localparam int SHAMT_W = 5;
    localparam int CODE_W  = 6;

    localparam logic [CODE_W-1:0] MAJOR_REG = 6'd0;
    localparam logic [CODE_W-1:0] FN_SLL    = 6'd0;
    localparam logic [CODE_W-1:0] FN_SRL    = 6'd2;
    localparam logic [CODE_W-1:0] FN_ADD    = 6'd32;
    localparam logic [CODE_W-1:0] FN_SUB    = 6'd34;
    localparam logic [CODE_W-1:0] FN_AND    = 6'd36;

    // Field layout, most significant first (the order is the encoding)
    typedef struct packed {
        logic [CODE_W-1:0]  major;
        logic [IDX_W-1:0]   src_a;
        logic [IDX_W-1:0]   src_b;
        logic [IDX_W-1:0]   dst;
        logic [SHAMT_W-1:0] amount;
        logic [CODE_W-1:0]  fcode;
    } rfmt_word_t;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_SHL,
        ALU_SHR
    } alu_sel_e;

endpackage

// File: rtl/rfx_decoder.sv
// Module rfx_decoder
// Purpose: splits the instruction word into its fields, picks the ALU
//          operation and flags words that cannot be executed.
// Assumes: purely combinational; valid gating is applied here so the
//          outputs illegal and wr_en are already qualified.
module rfx_decoder
    import rfx_pkg::*;
(
    input  logic [INSTR_W-1:0]  instr,
    input  logic                valid,
    output logic [IDX_W-1:0]    rd_a_idx,
    output logic [IDX_W-1:0]    rd_b_idx,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [SHAMT_W-1:0]  amount,
    output alu_sel_e            op,
    output logic                illegal,
    output logic                wr_en
);

    rfmt_word_t word;
    logic       code_known;
    logic       is_shift;
    logic       bad_word;

    assign word     = rfmt_word_t'(instr);
    assign rd_a_idx = word.src_a;
    assign rd_b_idx = word.src_b;
    assign wr_idx   = word.dst;
    assign amount   = word.amount;

    // Map the function code to an operation and note whether it exists
    always_comb begin
        op         = ALU_ADD;
        code_known = 1'b1;
        is_shift   = 1'b0;
        case (word.fcode)
            FN_ADD: op = ALU_ADD;
            FN_SUB: op = ALU_SUB;
            FN_AND: op = ALU_AND;
            FN_SLL: begin op = ALU_SHL; is_shift = 1'b1; end
            FN_SRL: begin op = ALU_SHR; is_shift = 1'b1; end
            default: code_known = 1'b0;
        endcase
    end

    // Reject other formats, unknown codes and shifts with a source in rs
    always_comb begin
        bad_word = (word.major != MAJOR_REG) || !code_known ||
                   (is_shift && (word.src_a != '0));
    end

    assign illegal = valid && bad_word;
    assign wr_en   = valid && !bad_word;

endmodule

// File: rtl/rfx_alu.sv
// Module rfx_alu
// Purpose: computes add, subtract, AND and logical shifts on W-bit data.
// Assumes: add/sub wrap silently; shifts act on operand b and fill with
//          zeros; the shift amount is narrower than W.
module rfx_alu
    import rfx_pkg::*;
#(
    parameter int W       = 32,
    parameter int SHIFT_W = 5
) (
    input  alu_sel_e              op,
    input  logic [W-1:0]          opa,
    input  logic [W-1:0]          opb,
    input  logic [SHIFT_W-1:0]    amount,
    output logic [W-1:0]          y
);

    // Select the operation result
    always_comb begin
        case (op)
            ALU_ADD: y = opa + opb;
            ALU_SUB: y = opa - opb;
            ALU_AND: y = opa & opb;
            ALU_SHL: y = opb << amount;
            ALU_SHR: y = opb >> amount;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/rfx_regfile.sv
// Module rfx_regfile
// Purpose: N x W register file with NRD combinational read ports, one
//          instruction write port and one debug write port.
// Assumes: synchronous active-low reset clears every entry; when both
//          write ports target one entry the instruction port wins.
module rfx_regfile #(
    parameter int W   = 32,
    parameter int N   = 32,
    parameter int NRD = 3,
    localparam int AW = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata,
    input  logic                    we_a,
    input  logic [AW-1:0]           waddr_a,
    input  logic [W-1:0]            wdata_a,
    input  logic                    we_b,
    input  logic [AW-1:0]           waddr_b,
    input  logic [W-1:0]            wdata_b
);

    logic [W-1:0] mem [N];

    for (genvar e = 0; e < N; e++) begin : g_entry
        logic hit_a;
        logic hit_b;
        assign hit_a = we_a && (waddr_a == AW'(e));
        assign hit_b = we_b && (waddr_b == AW'(e));

        // Hold or update one entry, instruction port first
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (hit_a) begin
                mem[e] <= wdata_a;
            end else if (hit_b) begin
                mem[e] <= wdata_b;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_read
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/rfmt_exec_unit.sv
// Module rfmt_exec_unit
// Purpose: executes one register-format instruction per cycle against an
//          internal register file; exposes a debug read/write port.
// Assumes: 32 registers (5-bit index fields); outputs describe the word
//          on instr_i in the same cycle; the write lands on the next edge.
module rfmt_exec_unit
    import rfx_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    localparam int RIDX_W  = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic                instr_vld_i,
    output logic [DATA_W-1:0]   result_o,
    output logic [RIDX_W-1:0]   dest_o,
    output logic                illegal_o,
    input  logic [RIDX_W-1:0]   dbg_addr_i,
    input  logic                dbg_we_i,
    input  logic [DATA_W-1:0]   dbg_wdata_i,
    output logic [DATA_W-1:0]   dbg_data_o
);

    localparam int NRD = 3;

    logic [IDX_W-1:0]            a_idx, b_idx, d_idx;
    logic [SHAMT_W-1:0]          amount;
    alu_sel_e                    op;
    logic                        illegal;
    logic                        wr_en;
    logic [NRD-1:0][RIDX_W-1:0]  raddr;
    logic [NRD-1:0][DATA_W-1:0]  rdata;
    logic [DATA_W-1:0]           alu_y;

    rfx_decoder u_dec (
        .instr    (instr_i),
        .valid    (instr_vld_i),
        .rd_a_idx (a_idx),
        .rd_b_idx (b_idx),
        .wr_idx   (d_idx),
        .amount   (amount),
        .op       (op),
        .illegal  (illegal),
        .wr_en    (wr_en)
    );

    assign raddr[0] = RIDX_W'(a_idx);
    assign raddr[1] = RIDX_W'(b_idx);
    assign raddr[2] = dbg_addr_i;

    rfx_regfile #(
        .W   (DATA_W),
        .N   (NUM_REGS),
        .NRD (NRD)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr   (raddr),
        .rdata   (rdata),
        .we_a    (wr_en),
        .waddr_a (RIDX_W'(d_idx)),
        .wdata_a (alu_y),
        .we_b    (dbg_we_i),
        .waddr_b (dbg_addr_i),
        .wdata_b (dbg_wdata_i)
    );

    rfx_alu #(
        .W       (DATA_W),
        .SHIFT_W (SHAMT_W)
    ) u_alu (
        .op     (op),
        .opa    (rdata[0]),
        .opb    (rdata[1]),
        .amount (amount),
        .y      (alu_y)
    );

    assign result_o   = illegal ? '0 : alu_y;
    assign dest_o     = RIDX_W'(d_idx);
    assign illegal_o  = illegal;
    assign dbg_data_o = rdata[2];

endmodule

// File: rtl/rfx_checker.sv
// Module rfx_checker
// Purpose: port-level properties of rfmt_exec_unit, attached by bind.
// Assumes: the default 32 x 32 configuration.
module rfx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic        instr_vld_i,
    input logic [31:0] result_o,
    input logic [4:0]  dest_o,
    input logic        illegal_o,
    input logic [4:0]  dbg_addr_i,
    input logic        dbg_we_i,
    input logic [31:0] dbg_data_o
);

    // R1
    dest_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dest_o == instr_i[15:11]);

    // R7
    major_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && instr_i[31:26] != 6'd0) |-> illegal_o);

    // R7
    shift_src_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && instr_i[31:26] == 6'd0 &&
         (instr_i[5:0] == 6'd0 || instr_i[5:0] == 6'd2) &&
         instr_i[25:21] != 5'd0) |-> illegal_o);

    // R7
    illegal_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> result_o == 32'd0);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld_i |-> !illegal_o);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(instr_vld_i) && !$past(dbg_we_i) &&
         dbg_addr_i == $past(dbg_addr_i)) |-> dbg_data_o == $past(dbg_data_o));

    // R10
    writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_vld_i) && !$past(illegal_o) &&
         dbg_addr_i == $past(dest_o)) |-> dbg_data_o == $past(result_o));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dbg_data_o == 32'd0);

endmodule

bind rfmt_exec_unit rfx_checker i_rfx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .instr_vld_i (instr_vld_i),
    .result_o    (result_o),
    .dest_o      (dest_o),
    .illegal_o   (illegal_o),
    .dbg_addr_i  (dbg_addr_i),
    .dbg_we_i    (dbg_we_i),
    .dbg_data_o  (dbg_data_o)
);

// File: tb/test_rfmt_exec_unit.sv
`timescale 1ns/1ps
module test_rfmt_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr_i;
    logic        instr_vld_i;
    logic [31:0] result_o;
    logic [4:0]  dest_o;
    logic        illegal_o;
    logic [4:0]  dbg_addr_i;
    logic        dbg_we_i;
    logic [31:0] dbg_wdata_i;
    logic [31:0] dbg_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    rfmt_exec_unit i_rfmt_exec_unit (
        .clk (clk), .rst_n (rst_n), .instr_i (instr_i), .instr_vld_i (instr_vld_i),
        .result_o (result_o), .dest_o (dest_o), .illegal_o (illegal_o),
        .dbg_addr_i (dbg_addr_i), .dbg_we_i (dbg_we_i),
        .dbg_wdata_i (dbg_wdata_i), .dbg_data_o (dbg_data_o)
    );

    function automatic logic [31:0] enc(input logic [5:0] mj, input logic [4:0] a,
            input logic [4:0] b, input logic [4:0] d, input logic [4:0] sh,
            input logic [5:0] fc);
        return {mj, a, b, d, sh, fc};
    endfunction

    function automatic bit exp_ill(input logic [31:0] w);
        logic [5:0] fc = w[5:0];
        bit known = (fc == 6'd0 || fc == 6'd2 || fc == 6'd32 || fc == 6'd34 || fc == 6'd36);
        return (w[31:26] != 6'd0) || !known ||
               ((fc == 6'd0 || fc == 6'd2) && w[25:21] != 5'd0);
    endfunction

    function automatic logic [31:0] exp_res(input logic [31:0] w);
        logic [31:0] a = model[w[25:21]];
        logic [31:0] b = model[w[20:16]];
        if (exp_ill(w)) return 32'd0;
        case (w[5:0])
            6'd32:   return a + b;
            6'd34:   return a - b;
            6'd36:   return a & b;
            6'd0:    return b << w[10:6];
            default: return b >> w[10:6];
        endcase
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        if (exp_ill(w)) return "R7";
        case (w[5:0])
            6'd32: return "R2";
            6'd34: return "R3";
            6'd36: return "R4";
            6'd0:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Run one instruction; checks outputs, old value before edge, new after
    task automatic run(input logic [31:0] w, input bit vld);
        logic [31:0] er;
        bit          ei;
        logic [4:0]  d = w[15:11];
        @(negedge clk);
        instr_i = w; instr_vld_i = vld; dbg_addr_i = d; dbg_we_i = 1'b0;
        #1;
        er = exp_res(w);
        ei = vld && exp_ill(w);
        check("R1 dest", {27'd0, dest_o}, {27'd0, d});
        check("R8/R7 illegal", {31'd0, illegal_o}, {31'd0, ei});
        if (vld) check(tag_of(w), result_o, er);
        check("R10 old value", dbg_data_o, model[d]);
        @(posedge clk);
        if (vld && !ei) model[d] = er;
        #1;
        check(vld ? "R10 new value" : "R8 no write", dbg_data_o, model[d]);
    endtask

    task automatic dbg_put(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        instr_vld_i = 1'b0; dbg_addr_i = a; dbg_we_i = 1'b1; dbg_wdata_i = v;
        @(posedge clk);
        model[a] = v;
        #1;
        dbg_we_i = 1'b0;
        check("R11 debug write", dbg_data_o, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr_vld_i = 1'b0; dbg_we_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
    endtask

    function automatic logic [31:0] rand_word();
        int unsigned k = $urandom % 16;
        logic [4:0] a = 5'($urandom);
        logic [4:0] b = 5'($urandom);
        logic [4:0] d = 5'($urandom);
        logic [4:0] s = 5'($urandom);
        logic [4:0] sa = ($urandom % 8 == 0) ? 5'($urandom | 1) : 5'd0;
        if (k < 3)       return enc(6'd0, a, b, d, s, 6'd32);
        else if (k < 5)  return enc(6'd0, a, b, d, s, 6'd34);
        else if (k < 7)  return enc(6'd0, a, b, d, s, 6'd36);
        else if (k < 9)  return enc(6'd0, sa, b, d, s, 6'd0);
        else if (k < 11) return enc(6'd0, sa, b, d, s, 6'd2);
        else if (k == 11) return enc(6'd0, a, b, d, s, 6'($urandom));
        else if (k == 12) return enc(6'($urandom | 1), a, b, d, s, 6'd32);
        else             return enc(6'd0, a, b, d, s, 6'd32);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; instr_i = '0; instr_vld_i = 1'b0;
        dbg_addr_i = '0; dbg_we_i = 1'b0; dbg_wdata_i = '0;
        do_reset();
        // R9: every register reads zero after reset
        for (int i = 0; i < 32; i++) begin
            dbg_addr_i = 5'(i); #0.2;
            check("R9 reset clear", dbg_data_o, 32'd0);
        end
        // Preload operands through the debug port (R11)
        for (int i = 0; i < 32; i++) dbg_put(5'(i), $urandom);
        // Directed corner cases
        dbg_put(5'd17, 32'hFFFF_FFFF); dbg_put(5'd18, 32'd2);
        run(32'h0232_4020, 1'b1);                       // R2 wrap, encoding example
        dbg_put(5'd3, 32'd0); dbg_put(5'd4, 32'd1);
        run(enc(6'd0, 5'd3, 5'd4, 5'd9, 5'd0, 6'd34), 1'b1); // R3 0-1
        run(enc(6'd0, 5'd17, 5'd18, 5'd10, 5'd0, 6'd36), 1'b1); // R4
        dbg_put(5'd5, 32'h8000_0001);
        run(enc(6'd0, 5'd0, 5'd5, 5'd11, 5'd31, 6'd0), 1'b1);  // R5 by 31
        run(enc(6'd0, 5'd0, 5'd5, 5'd12, 5'd31, 6'd2), 1'b1);  // R6 by 31
        run(enc(6'd0, 5'd0, 5'd5, 5'd13, 5'd0, 6'd2), 1'b1);   // R6 by 0
        run(enc(6'd0, 5'd1, 5'd5, 5'd14, 5'd4, 6'd0), 1'b1);   // R7 shift with rs
        run(enc(6'd8, 5'd17, 5'd18, 5'd15, 5'd0, 6'd32), 1'b1); // R7 major
        run(enc(6'd0, 5'd17, 5'd18, 5'd16, 5'd0, 6'd33), 1'b1); // R7 code
        run(enc(6'd0, 5'd17, 5'd18, 5'd19, 5'd0, 6'd32), 1'b0); // R8 invalid
        run(enc(6'd0, 5'd19, 5'd19, 5'd19, 5'd0, 6'd32), 1'b1); // R10 rd=rs=rt
        // R11: same-cycle collision, instruction result wins
        @(negedge clk);
        instr_i = enc(6'd0, 5'd17, 5'd18, 5'd20, 5'd0, 6'd32); instr_vld_i = 1'b1;
        dbg_addr_i = 5'd20; dbg_we_i = 1'b1; dbg_wdata_i = 32'hDEAD_BEEF;
        @(posedge clk);
        model[20] = model[17] + model[18];
        #1;
        dbg_we_i = 1'b0; instr_vld_i = 1'b0;
        check("R11 collision priority", dbg_data_o, model[20]);
        // Constrained random mix
        for (int n = 0; n < 400; n++) run(rand_word(), ($urandom % 10) != 0);
        // R9: reset after activity clears everything again
        do_reset();
        for (int i = 0; i < 32; i++) begin
            dbg_addr_i = 5'(i); #0.1;
            check("R9 second reset", dbg_data_o, 32'd0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule